// File: doc/BRIEF.md
# Serial Controller Configuration Port Sequencer

This block is the processor-facing register port of a programmable serial controller. It samples active-low chip select, read and write strobes and a port select line that picks either the data port or the control/status port. Writes to the data port fill the transmit holding register and raise a one-cycle load pulse for the transmitter. Writes to the control port are routed by a small sequencer. After any reset, the first control write is the mode word. If that mode word selects synchronous operation, one or two sync characters follow it. Every control write after that is a command.

Reads return the received character on the data port, or the status word on the control port. Both are supplied by the serial side as plain inputs. One command bit sends the sequencer back to waiting for a mode word. Another command bit gives the receiver a single-cycle pulse that clears its error flags. The block has no serial shifting, baud generation or modem pins.

Top module: `sercfg_regseq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all outputs are zero and the sequencer waits for a mode word.
- R2: The first accepted control write (`sel_ctl`=1) after any reset is stored in `mode_word`. If mode bits [1:0] are not 00 (asynchronous), the next control write is a command.
- R3: If mode bits [1:0] are 00 (synchronous), the control writes that follow are sync characters. There is one when mode bit 7 is 1 and two when bit 7 is 0. The first goes to `sync_chars[7:0]`, the second to `sync_chars[15:8]`.
- R4: Once the mode word and any sync characters are loaded, every control write replaces `cmd_word`, however many are written.
- R5: A command write with bit 6 set clears `cmd_word` and returns the sequencer to waiting for a mode word. The mode word and sync characters keep their values until they are written again.
- R6: A data write (`sel_ctl`=0) loads `tx_data` at any point in the sequence, and it does not move the sequencer.
- R7: `dout` is registered. One cycle after a read access it holds `stat_word` (for `sel_ctl`=1) or `rx_data` (for `sel_ctl`=0). In every other cycle it is zero.
- R8: A command write with bit 4 set raises `err_clr` for exactly one cycle.
- R9: Strobes are ignored while `cs_n` is high. A cycle with both `rd_n` and `wr_n` low is no access.
- R10: A write strobe held low for several cycles counts as a single write.
- R11: Registers and the `tx_load` pulse change on the first clock edge at which the write strobe is seen. `tx_load` is high for exactly that one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel_ctl | input | 1 | 1 selects the control/status port, 0 the data port |
| din | input | DW | Write data from the processor |
| dout | output | DW | Registered read data |
| rx_data | input | DW | Received character from the receiver |
| stat_word | input | DW | Status word from the serial logic |
| mode_word | output | DW | Latched mode word |
| sync_chars | output | NSYNC*DW | Sync characters, first one in the low byte |
| cmd_word | output | DW | Latched command word |
| tx_data | output | DW | Transmit holding register |
| tx_load | output | 1 | One-cycle pulse on a data-port write |
| err_clr | output | 1 | One-cycle pulse that clears receiver error flags |

## Verification
The bench uses the default parameters: an 8-bit data width and two sync character slots. With these values both the single-sync and double-sync paths can be reached, and the internal-reset and error-clear command bits sit at positions the bench can drive directly. A behavioural model follows each accepted strobe and is compared with every output after each clock. Stimulus covers asynchronous and synchronous modes, an internal reset, a hardware reset in the middle of the sequence, held strobes, and accesses that must be ignored.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    typedef enum logic [1:0] {
        SQ_MODE = 2'd0,
        SQ_SYNC = 2'd1,
        SQ_CMD  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sercfg_access.sv
module sercfg_access (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_go,
    output logic rd_go
);

    logic wr_lvl;
    logic held_d, held_q;

    always_comb begin
        wr_lvl = !cs_n && !wr_n && rd_n;
        rd_go  = !cs_n && !rd_n && wr_n;
        held_d = wr_lvl;
        wr_go  = wr_lvl && !held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= held_d;
    end

endmodule

// File: rtl/sercfg_seq.sv
module sercfg_seq
    import sercfg_pkg::*;
#(
    parameter int DW        = 8,
    parameter int NSYNC     = 2,
    parameter int BAUD_LSB  = 0,
    parameter int BAUD_W    = 2,
    parameter int DSYNC_BIT = 7,
    parameter int IRST_BIT  = 6,
    parameter int ECLR_BIT  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_go,
    input  logic                      sel_ctl,
    input  logic [DW-1:0]             din,
    output logic [DW-1:0]             mode_word,
    output logic [NSYNC-1:0][DW-1:0]  sync_arr,
    output logic [DW-1:0]             cmd_word,
    output logic [DW-1:0]             tx_data,
    output logic                      tx_load,
    output logic                      err_clr
);

    localparam int SC_W = $clog2(NSYNC + 1);

    typedef struct packed {
        seq_state_e               st;
        logic [SC_W-1:0]          sidx;
        logic [DW-1:0]            mode;
        logic [NSYNC-1:0][DW-1:0] sync;
        logic [DW-1:0]            cmd;
        logic [DW-1:0]            txd;
        logic                     txl;
        logic                     ecl;
    } seq_regs_t;

    seq_regs_t q, d;
    logic [SC_W-1:0] need;
    logic            is_sync;

    always_comb begin
        d       = q;
        d.txl   = 1'b0;
        d.ecl   = 1'b0;
        is_sync = (din[BAUD_LSB +: BAUD_W] == '0);
        need    = q.mode[DSYNC_BIT] ? SC_W'(1) : SC_W'(NSYNC);
        if (wr_go) begin
            if (!sel_ctl) begin
                d.txd = din;
                d.txl = 1'b1;
            end else begin
                unique case (q.st)
                    SQ_MODE: begin
                        d.mode = din;
                        d.sidx = '0;
                        d.st   = is_sync ? SQ_SYNC : SQ_CMD;
                    end
                    SQ_SYNC: begin
                        for (int k = 0; k < NSYNC; k++) begin
                            if (SC_W'(k) == q.sidx) d.sync[k] = din;
                        end
                        d.sidx = SC_W'(q.sidx + SC_W'(1));
                        if (SC_W'(q.sidx + SC_W'(1)) >= need) d.st = SQ_CMD;
                    end
                    default: begin
                        d.ecl = din[ECLR_BIT];
                        if (din[IRST_BIT]) begin
                            d.cmd  = '0;
                            d.sidx = '0;
                            d.st   = SQ_MODE;
                        end else begin
                            d.cmd = din;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign mode_word = q.mode;
    assign sync_arr  = q.sync;
    assign cmd_word  = q.cmd;
    assign tx_data   = q.txd;
    assign tx_load   = q.txl;
    assign err_clr   = q.ecl;

endmodule

// File: rtl/sercfg_rdmux.sv
module sercfg_rdmux #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_go,
    input  logic          sel_ctl,
    input  logic [DW-1:0] rx_data,
    input  logic [DW-1:0] stat_word,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] dout_d, dout_q;

    always_comb begin
        dout_d = '0;
        if (rd_go) dout_d = sel_ctl ? stat_word : rx_data;
    end

    always_ff @(posedge clk) begin
        if (rst) dout_q <= '0;
        else     dout_q <= dout_d;
    end

    assign dout = dout_q;

endmodule

// File: rtl/sercfg_regseq.sv
module sercfg_regseq #(
    parameter int DW        = 8,
    parameter int NSYNC     = 2,
    parameter int BAUD_LSB  = 0,
    parameter int BAUD_W    = 2,
    parameter int DSYNC_BIT = 7,
    parameter int IRST_BIT  = 6,
    parameter int ECLR_BIT  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic                  sel_ctl,
    input  logic [DW-1:0]         din,
    output logic [DW-1:0]         dout,
    input  logic [DW-1:0]         rx_data,
    input  logic [DW-1:0]         stat_word,
    output logic [DW-1:0]         mode_word,
    output logic [NSYNC*DW-1:0]   sync_chars,
    output logic [DW-1:0]         cmd_word,
    output logic [DW-1:0]         tx_data,
    output logic                  tx_load,
    output logic                  err_clr
);

    logic wr_go, rd_go;
    logic [NSYNC-1:0][DW-1:0] sync_arr;

    sercfg_access i_access (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .wr_go (wr_go),
        .rd_go (rd_go)
    );

    sercfg_seq #(
        .DW        (DW),
        .NSYNC     (NSYNC),
        .BAUD_LSB  (BAUD_LSB),
        .BAUD_W    (BAUD_W),
        .DSYNC_BIT (DSYNC_BIT),
        .IRST_BIT  (IRST_BIT),
        .ECLR_BIT  (ECLR_BIT)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_go     (wr_go),
        .sel_ctl   (sel_ctl),
        .din       (din),
        .mode_word (mode_word),
        .sync_arr  (sync_arr),
        .cmd_word  (cmd_word),
        .tx_data   (tx_data),
        .tx_load   (tx_load),
        .err_clr   (err_clr)
    );

    sercfg_rdmux #(.DW(DW)) i_rdmux (
        .clk       (clk),
        .rst       (rst),
        .rd_go     (rd_go),
        .sel_ctl   (sel_ctl),
        .rx_data   (rx_data),
        .stat_word (stat_word),
        .dout      (dout)
    );

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        assign sync_chars[g*DW +: DW] = sync_arr[g];
    end

endmodule

// File: rtl/sercfg_regseq_chk.sv
module sercfg_regseq_chk #(
    parameter int DW    = 8,
    parameter int NSYNC = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                cs_n,
    input logic                rd_n,
    input logic                wr_n,
    input logic                sel_ctl,
    input logic [DW-1:0]       din,
    input logic [DW-1:0]       dout,
    input logic [DW-1:0]       rx_data,
    input logic [DW-1:0]       stat_word,
    input logic [DW-1:0]       mode_word,
    input logic [NSYNC*DW-1:0] sync_chars,
    input logic [DW-1:0]       cmd_word,
    input logic [DW-1:0]       tx_data,
    input logic                tx_load,
    input logic                err_clr
);

    logic wr_lvl, rd_lvl;
    assign wr_lvl = !cs_n && !wr_n && rd_n;
    assign rd_lvl = !cs_n && !rd_n && wr_n;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cmd_word == '0 && mode_word == '0 && !tx_load && !err_clr && dout == '0));

    p_txload_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);

    p_eclr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> !err_clr);

    p_txdata_load_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_lvl && !$past(wr_lvl) && !$past(rst) && !sel_ctl)
            |=> (tx_load && tx_data == $past(din) && $stable(cmd_word) && $stable(mode_word)));

    p_deselect_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (cs_n || (!rd_n && !wr_n))
            |=> ($stable(cmd_word) && $stable(mode_word) && $stable(sync_chars)
                 && !tx_load && !err_clr && dout == '0));

    p_held_write_once_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_lvl && $past(wr_lvl) && !$past(rst))
            |=> ($stable(cmd_word) && $stable(tx_data) && !tx_load && !err_clr));

    p_status_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_lvl && sel_ctl) |=> (dout == $past(stat_word)));

    p_data_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_lvl && !sel_ctl) |=> (dout == $past(rx_data)));

    p_dout_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_lvl |=> (dout == '0));

endmodule

bind sercfg_regseq sercfg_regseq_chk #(.DW(DW), .NSYNC(NSYNC)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .sel_ctl    (sel_ctl),
    .din        (din),
    .dout       (dout),
    .rx_data    (rx_data),
    .stat_word  (stat_word),
    .mode_word  (mode_word),
    .sync_chars (sync_chars),
    .cmd_word   (cmd_word),
    .tx_data    (tx_data),
    .tx_load    (tx_load),
    .err_clr    (err_clr)
);

// File: tb/test_sercfg_regseq.sv
`timescale 1ns/1ps
module test_sercfg_regseq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel_ctl = 1'b0;
    logic [7:0]  din = '0, rx_data = '0, stat_word = '0;
    logic [7:0]  dout, mode_word, cmd_word, tx_data;
    logic [15:0] sync_chars;
    logic        tx_load, err_clr;

    always #4 clk = ~clk;

    sercfg_regseq i_sercfg_regseq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .sel_ctl(sel_ctl), .din(din), .dout(dout), .rx_data(rx_data),
        .stat_word(stat_word), .mode_word(mode_word), .sync_chars(sync_chars),
        .cmd_word(cmd_word), .tx_data(tx_data), .tx_load(tx_load), .err_clr(err_clr)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int txl_seen = 0;
    bit cmp_on = 1'b0;

    // behavioural model: 0 await mode, 1 collecting sync, 2 commands
    int         m_phase = 0;
    int         m_nsync = 0;
    int         m_got = 0;
    logic [7:0] m_mode = '0, m_cmd = '0, m_tx = '0, m_dout = '0;
    logic [7:0] m_sync [2] = '{8'h00, 8'h00};
    bit         m_txl = 1'b0, m_ecl = 1'b0, m_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit wa, ra, go;
        cycles++;
        wa = !cs_n && !wr_n && rd_n;
        ra = !cs_n && !rd_n && wr_n;
        if (rst) begin
            m_phase = 0; m_got = 0; m_mode = '0; m_cmd = '0; m_tx = '0; m_dout = '0;
            m_sync[0] = '0; m_sync[1] = '0; m_txl = 0; m_ecl = 0; m_prev = 0;
        end else begin
            go = wa && !m_prev;
            m_prev = wa;
            m_txl = 0;
            m_ecl = 0;
            m_dout = ra ? (sel_ctl ? stat_word : rx_data) : 8'h00;
            if (go && !sel_ctl) begin
                m_tx = din;
                m_txl = 1;
            end else if (go) begin
                if (m_phase == 0) begin
                    m_mode = din;
                    m_got = 0;
                    if (din[1:0] == 2'b00) begin
                        m_phase = 1;
                        m_nsync = din[7] ? 1 : 2;
                    end else m_phase = 2;
                end else if (m_phase == 1) begin
                    m_sync[m_got] = din;
                    m_got++;
                    if (m_got == m_nsync) m_phase = 2;
                end else begin
                    m_ecl = din[4];
                    if (din[6]) begin
                        m_cmd = '0;
                        m_phase = 0;
                    end else m_cmd = din;
                end
            end
        end
        #2;
        if (cmp_on) begin
            if (tx_load) txl_seen++;
            chk(mode_word == m_mode, "R2 mode_word", mode_word, m_mode);
            chk(sync_chars == {m_sync[1], m_sync[0]}, "R3 sync_chars", sync_chars, {m_sync[1], m_sync[0]});
            chk(cmd_word == m_cmd, "R4 cmd_word", cmd_word, m_cmd);
            chk(tx_data == m_tx, "R6 tx_data", tx_data, m_tx);
            chk(tx_load == m_txl, "R11 tx_load", tx_load, m_txl);
            chk(err_clr == m_ecl, "R8 err_clr", err_clr, m_ecl);
            chk(dout == m_dout, "R7 dout", dout, m_dout);
        end
    end

    task automatic idle();
        @(negedge clk);
        cs_n = 1; rd_n = 1; wr_n = 1;
    endtask

    task automatic wr(input bit ctl, input logic [7:0] v, input int hold);
        @(negedge clk);
        cs_n = 0; wr_n = 0; rd_n = 1; sel_ctl = ctl; din = v;
        for (int i = 1; i < hold; i++) @(negedge clk);
        idle();
    endtask

    task automatic rd(input bit ctl, input logic [7:0] rxv, input logic [7:0] stv);
        @(negedge clk);
        cs_n = 0; rd_n = 0; wr_n = 1; sel_ctl = ctl; rx_data = rxv; stat_word = stv;
        idle();
    endtask

    always @(posedge clk) begin
        if (cycles > 5000) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=%0d expected<5000 cycles", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1;
        @(negedge clk);
        chk(mode_word == 0 && cmd_word == 0 && sync_chars == 0 && !tx_load && !err_clr && dout == 0,
            "R1 reset state", {mode_word, cmd_word}, 0);
        rst = 0;
        @(negedge clk);
        chk(cmd_word == 0 && tx_data == 0 && dout == 0, "R1 after release", cmd_word, 0);

        // asynchronous mode, then commands
        wr(1, 8'h4E, 1);
        wr(1, 8'h05, 1);
        chk(cmd_word == 8'h05, "R2 async mode skips sync", cmd_word, 8'h05);
        wr(1, 8'h27, 1);
        chk(cmd_word == 8'h27, "R4 second command", cmd_word, 8'h27);

        // data write and reads
        wr(0, 8'hA5, 1);
        chk(tx_data == 8'hA5 && cmd_word == 8'h27, "R6 data write", tx_data, 8'hA5);
        rd(0, 8'h3C, 8'h85);
        rd(1, 8'h3C, 8'h85);

        // internal reset, synchronous double sync
        wr(1, 8'h40, 1);
        wr(1, 8'h0C, 1);
        chk(mode_word == 8'h0C, "R5 mode after internal reset", mode_word, 8'h0C);
        wr(0, 8'h11, 1);
        wr(1, 8'h16, 1);
        wr(1, 8'h17, 1);
        chk(sync_chars == 16'h1716, "R3 double sync", sync_chars, 16'h1716);
        wr(1, 8'h15, 1);
        chk(cmd_word == 8'h15, "R8 command with error clear", cmd_word, 8'h15);

        // internal reset with error clear, single sync
        wr(1, 8'h50, 1);
        chk(cmd_word == 8'h00 && sync_chars == 16'h1716, "R5 clears command keeps sync", cmd_word, 0);
        wr(1, 8'h80, 1);
        wr(1, 8'hAA, 1);
        wr(1, 8'h01, 1);
        chk(sync_chars == 16'h17AA && cmd_word == 8'h01, "R3 single sync", sync_chars, 16'h17AA);

        // ignored accesses
        @(negedge clk); cs_n = 1; wr_n = 0; rd_n = 1; sel_ctl = 1; din = 8'hFF;
        @(negedge clk); cs_n = 0; wr_n = 0; rd_n = 0;
        idle();
        @(negedge clk);
        chk(cmd_word == 8'h01 && dout == 0, "R9 ignored accesses", cmd_word, 8'h01);

        // held strobe
        txl_seen = 0;
        wr(0, 8'h66, 4);
        wr(1, 8'h02, 5);
        @(negedge clk);
        chk(txl_seen == 1, "R10 held write pulses once", txl_seen, 1);
        chk(cmd_word == 8'h02, "R10 held command", cmd_word, 8'h02);

        // hardware reset mid-sequence
        wr(1, 8'h40, 1);
        wr(1, 8'h00, 1);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk(mode_word == 0 && sync_chars == 0, "R1 hardware reset", mode_word, 0);
        wr(1, 8'h4F, 1);
        wr(1, 8'h33, 1);
        chk(cmd_word == 8'h33 && sync_chars == 0, "R2 mode after hardware reset", cmd_word, 8'h33);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule